// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer Mode

This block stores eight single-bit values that are written one at a time from a shared data input. A 3-bit select names the bit of interest, and two active-low controls, enable and clear, choose one of four modes. The modes are: write the data input into the selected bit, hold every bit, act as a 1-of-8 demultiplexer, or clear every bit. It serves as a small working register, a serial-to-parallel holding register, or an active-high one-hot decoder.

The implementation is clocked. Stored bits change only on the rising clock edge. In the two modes with clear asserted, the outputs are forced combinationally. In the demultiplexer mode, the selected output copies the data input in the same cycle and every other output is low. In the clear mode, all outputs are low at once. Both of these modes empty the storage at the next edge.

Top module: `addr_bit_latch`

## Requirements
- R1: After the asynchronous active-low reset, all eight stored bits and all outputs are 0.
- R2: With clear high and enable low (write mode), at the rising clock edge the bit selected by `sel` takes the value of `dataIn`, and all other bits keep their previous values.
- R3: With clear and enable both high (hold mode), no stored bit changes, whatever `dataIn` and `sel` do.
- R4: With clear and enable both low (demultiplexer mode), output `sel` equals `dataIn` in the same cycle and every other output is 0.
- R5: With clear low and enable high (clear mode), all outputs are 0 in the same cycle, whatever `dataIn` and `sel` are, and every stored bit is 0 after the next rising edge.
- R6: `sel` is an unsigned binary index with bit 2 as the most significant bit: value 0 addresses `q[0]` and value 7 addresses `q[7]`.
- R7: After a clock edge spent in demultiplexer mode, the stored contents are all zero. A following hold mode shows zeros and does not bring back bits written earlier.
- R8: In write mode the outputs show the stored bits and are not transparent. A write becomes visible on `q` only after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 1 | Single-bit data value |
| sel | input | 3 | Binary index of the addressed bit |
| enN | input | 1 | Active-low enable |
| clrN | input | 1 | Active-low clear |
| q | output | 8 | Parallel outputs |

## Verification
A stored bit corrupted by a write to the wrong index, or by an edge in hold mode, reaches `q` one cycle later, provided the block is in write or hold mode. In clear mode and demultiplexer mode the outputs are forced, so such corruption stays hidden until clear is released. For that reason the bench checks after every edge and always returns to hold mode after a decode or clear sequence. A missing flush at a demultiplexer-mode edge appears as soon as hold mode resumes: earlier written bits reappear on `q`.

// File: rtl/addr_bit_latch_pkg.sv
package addr_bit_latch_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE  = 2'b00,
    MODE_HOLD   = 2'b01,
    MODE_DEMUX  = 2'b10,
    MODE_CLEAR  = 2'b11
  } latchMode_e;

  // strobes from the control decoder to the storage datapath
  typedef struct packed {
    logic wrStrobe;   // write the addressed bit at the edge
    logic zeroStore;  // empty every bit at the edge
    logic forceLow;   // outputs come from the forced path, not storage
    logic decodeOut;  // forced path passes data to the addressed output
  } latchCtl_t;

endpackage

// File: rtl/addr_bit_latch_ctrl.sv
module addr_bit_latch_ctrl
  import addr_bit_latch_pkg::*;
#(
  parameter int NUM_BITS = 8,
  localparam int SEL_W = $clog2(NUM_BITS)
) (
  input  logic                enN,
  input  logic                clrN,
  input  logic [SEL_W-1:0]    sel,
  output latchCtl_t           ctl,
  output logic [NUM_BITS-1:0] selHot
);

  latchMode_e mode;

  always_comb begin
    unique case ({~clrN, enN})
      2'b00:   mode = MODE_WRITE;
      2'b01:   mode = MODE_HOLD;
      2'b10:   mode = MODE_DEMUX;
      default: mode = MODE_CLEAR;
    endcase
  end

  always_comb begin
    ctl = '0;
    unique case (mode)
      MODE_WRITE: ctl.wrStrobe = 1'b1;
      MODE_HOLD:  ;
      MODE_DEMUX: begin
        ctl.zeroStore = 1'b1;
        ctl.forceLow  = 1'b1;
        ctl.decodeOut = 1'b1;
      end
      default: begin
        ctl.zeroStore = 1'b1;
        ctl.forceLow  = 1'b1;
      end
    endcase
  end

  // binary index to one-hot: bit i is addressed by sel value i
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_hot
    assign selHot[i] = (sel == SEL_W'(i));
  end

endmodule

// File: rtl/addr_bit_latch_dp.sv
module addr_bit_latch_dp
  import addr_bit_latch_pkg::*;
#(
  parameter int NUM_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dataIn,
  input  latchCtl_t           ctl,
  input  logic [NUM_BITS-1:0] selHot,
  output logic [NUM_BITS-1:0] qOut
);

  logic [NUM_BITS-1:0] store;

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        store[i] <= 1'b0;
      else if (ctl.zeroStore)
        store[i] <= 1'b0;
      else if (ctl.wrStrobe && selHot[i])
        store[i] <= dataIn;
    end
  end

  always_comb begin
    if (ctl.forceLow)
      qOut = (ctl.decodeOut && dataIn) ? selHot : '0;
    else
      qOut = store;
  end

  // R2
  wr_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrStrobe |=> ((store & $past(selHot)) == ($past(dataIn) ? $past(selHot) : '0)));

  // R2
  wr_others_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrStrobe |=> ((store & ~$past(selHot)) == ($past(store) & ~$past(selHot))));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.wrStrobe && !ctl.zeroStore) |=> $stable(store));

  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.zeroStore |=> (store == '0));

  // R4
  demux_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.decodeOut |-> ($onehot0(qOut) && ((qOut & ~selHot) == '0)));

  // R5
  clear_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.forceLow && !ctl.decodeOut) |-> (qOut == '0));

endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch
  import addr_bit_latch_pkg::*;
#(
  parameter int NUM_BITS = 8,
  localparam int SEL_W = $clog2(NUM_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dataIn,
  input  logic [SEL_W-1:0]    sel,
  input  logic                enN,
  input  logic                clrN,
  output logic [NUM_BITS-1:0] q
);

  latchCtl_t           ctl;
  logic [NUM_BITS-1:0] selHot;

  addr_bit_latch_ctrl #(.NUM_BITS(NUM_BITS)) u_ctrl (
    .enN    (enN),
    .clrN   (clrN),
    .sel    (sel),
    .ctl    (ctl),
    .selHot (selHot)
  );

  addr_bit_latch_dp #(.NUM_BITS(NUM_BITS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .dataIn (dataIn),
    .ctl    (ctl),
    .selHot (selHot),
    .qOut   (q)
  );

endmodule

// File: tb/addr_bit_latch_test.sv
module addr_bit_latch_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dataIn = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       enN = 1'b1;
  logic       clrN = 1'b1;
  logic [7:0] q;

  int checks = 0;
  int errors = 0;
  logic [7:0] model = 8'h00;

  always #2 clk = ~clk;

  addr_bit_latch uut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .sel(sel),
    .enN(enN), .clrN(clrN), .q(q)
  );

  function automatic logic [7:0] expectQ(logic d, logic [2:0] s, logic e, logic c);
    if (!c) return (!e && d) ? (8'h01 << s) : 8'h00;
    return model;
  endfunction

  task automatic check(string tag, logic [7:0] exp);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s: q=%h expected %h", tag, q, exp);
    end
  endtask

  // drive one cycle of inputs, check before the edge, update model at the edge
  task automatic step(string tag, logic d, logic [2:0] s, logic e, logic c);
    @(negedge clk);
    dataIn = d; sel = s; enN = e; clrN = c;
    #1 check(tag, expectQ(d, s, e, c));
    @(posedge clk);
    if (!c) model = 8'h00;
    else if (!e) model[s] = d;
  endtask

  task automatic testReset();
    #1 check("R1 reset", 8'h00);
    rstN = 1'b1;
    step("R1 after reset", 1'b1, 3'd5, 1'b1, 1'b1);
  endtask

  task automatic testWrite();
    // walk the selects; before each edge q must not show the new write (R8)
    for (int i = 0; i < 8; i++)
      step("R2 R6 R8 write walk", (i % 3) != 1, 3'(i), 1'b0, 1'b1);
    step("R2 write check", 1'b0, 3'd0, 1'b1, 1'b1);
    step("R6 sel7 clear bit", 1'b0, 3'd7, 1'b0, 1'b1);
    step("R6 sel7 result", 1'b0, 3'd0, 1'b1, 1'b1);
  endtask

  task automatic testHold();
    for (int i = 0; i < 10; i++)
      step("R3 hold ignores inputs", 1'(i), 3'(i * 3), 1'b1, 1'b1);
  endtask

  task automatic testDemux();
    step("R2 preload", 1'b1, 3'd2, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) begin
      step("R4 R6 demux data1", 1'b1, 3'(i), 1'b0, 1'b0);
      step("R4 demux data0", 1'b0, 3'(i), 1'b0, 1'b0);
    end
    step("R7 hold after demux", 1'b1, 3'd2, 1'b1, 1'b1);
    step("R7 zeros persist", 1'b1, 3'd4, 1'b1, 1'b1);
  endtask

  task automatic testClear();
    for (int i = 0; i < 8; i++) step("R2 fill", 1'b1, 3'(i), 1'b0, 1'b1);
    step("R2 filled", 1'b0, 3'd0, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++)
      step("R5 clear forces low", 1'b1, 3'(i * 2 + 1), 1'b1, 1'b0);
    step("R5 cleared store", 1'b1, 3'd3, 1'b1, 1'b1);
  endtask

  task automatic testRandom();
    for (int i = 0; i < 300; i++)
      step("R2 R3 R4 R5 random", 1'($urandom), 3'($urandom), 1'($urandom), ($urandom % 4) != 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testWrite();
    testHold();
    testDemux();
    testClear();
    testRandom();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule